// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns one asynchronous external interrupt pin into an interrupt request for a small microcontroller core. The pin passes through a synchronizer and a sampling register. A two-bit sense field then chooses the trigger: a low level, a falling edge or a rising edge. One code is reserved and never triggers anything.

In the edge modes a detected edge sets a sticky pending flag. The flag stays set until the core acknowledges it, until software writes a one to clear it, or until the sense field leaves the edge modes. In low-level mode the pending output follows the synchronized pin and does not latch. The request to the core is the pending output gated by both the source enable and the global enable. A separate level output reports the synchronized pin state to the wake logic.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset with the pin held high, pending_o, req_o and level_o are 0, and releasing reset does not set pending_o in falling-edge mode.
- R2: With sense_i = 2'b00 (low level), pending_o is 1 exactly while the synchronized pin is low and returns to 0 once the pin is back high, with no latching.
- R3: With sense_i = 2'b01 (reserved), pending_o and req_o stay 0 for any pin activity.
- R4: With sense_i = 2'b10, a high-to-low transition of the pin sets pending_o, which stays 1 after the pin returns high.
- R5: With sense_i = 2'b11, a low-to-high transition of the pin sets pending_o, and a high-to-low transition does not.
- R6: A pin change is visible on level_o and on the low-level pending_o after two rising clock edges, and on an edge-mode pending_o after three.
- R7: In an edge mode, a pin pulse lasting two clock periods sets pending_o.
- R8: req_o is 1 only when pending_o, gie_i and src_en_i are all 1. The pending flag is set whether or not the enables are on.
- R9: A one-cycle ack_i or clr_i clears the edge-mode pending flag on the next edge. When a new edge is detected in the same cycle, the set wins (default SET_WINS = 1).
- R10: Switching sense_i from an edge mode to the low or reserved code clears the sticky flag, so a later return to an edge mode shows pending_o = 0 until a new edge occurs.
- R11: level_o is 1 exactly while the synchronized pin is low, independent of sense_i and of both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| sense_i | input | 2 | Trigger select: 00 low, 01 reserved, 10 falling, 11 rising |
| src_en_i | input | 1 | Enable for this interrupt source |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | One-cycle acknowledge from the core |
| clr_i | input | 1 | Write-one-to-clear strobe for the pending flag |
| pending_o | output | 1 | Pending flag (sticky in edge modes, level in low mode) |
| req_o | output | 1 | Gated interrupt request to the core |
| level_o | output | 1 | Synchronized pin-low status for the wake logic |

## Verification
A wrong synchronizer or sample state shows up as a spurious or missing edge. In that case pending_o rises when it should not, or fails to rise, exactly three clock edges after the pin change. A corrupt preset would show a pending flag right after reset. A stuck or mis-prioritized pending flag shows on the edge after an ack or clear strobe, as pending_o and req_o staying up or dropping a freshly detected edge. A level-path fault shows two edges after the pin moves, as level_o or the low-mode request disagreeing with the pin.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   function automatic logic is_edge_mode(input logic [1:0] code);
      return code[1];
   endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int STAGES     = 2,
   parameter bit PRESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic cur_o,
   output logic prev_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{PRESET_VAL}};
      end else begin
         chain_q <= {chain_q[LAST-1:0], pin_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= PRESET_VAL;
      end else begin
         prev_q <= chain_q[LAST];
      end
   end

   assign cur_o  = chain_q[LAST];
   assign prev_o = prev_q;

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
   import ext_irq_pkg::*;
(
   input  logic [1:0] sense_i,
   input  logic       cur_i,
   input  logic       prev_i,
   output logic       hit_o
);
   logic fell, rose;

   assign fell = prev_i & ~cur_i;
   assign rose = ~prev_i & cur_i;

   always_comb begin
      case (sense_e'(sense_i))
         SENSE_FALL: hit_o = fell;
         SENSE_RISE: hit_o = rose;
         default:    hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode_i,
   input  logic hit_i,
   input  logic ack_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q, flag_d, drop;

   assign drop = ack_i | clr_i;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (!edge_mode_i)  flag_d = 1'b0;
         else if (hit_i)    flag_d = 1'b1;
         else if (drop)     flag_d = 1'b0;
         else               flag_d = flag_q;
      end

      assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode_i && hit_i) |=> flag_o);
   end else begin : g_clear_first
      always_comb begin
         if (!edge_mode_i)  flag_d = 1'b0;
         else if (drop)     flag_d = 1'b0;
         else if (hit_i)    flag_d = 1'b1;
         else               flag_d = flag_q;
      end

      assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode_i && hit_i && !drop) |=> flag_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && drop && !hit_i) |=> !flag_o);

   assert_leave_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode_i |=> !flag_o);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sense_i,
   input  logic       src_en_i,
   input  logic       gie_i,
   input  logic       ack_i,
   input  logic       clr_i,
   output logic       pending_o,
   output logic       req_o,
   output logic       level_o
);
   logic pin_cur, pin_prev, hit, flag, edge_mode;

   assign edge_mode = is_edge_mode(sense_i);

   irq_pin_sync #(.STAGES(SYNC_STAGES), .PRESET_VAL(1'b1)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .cur_o  (pin_cur),
      .prev_o (pin_prev)
   );

   irq_edge_detect u_edge (
      .sense_i (sense_i),
      .cur_i   (pin_cur),
      .prev_i  (pin_prev),
      .hit_o   (hit)
   );

   irq_pending #(.SET_WINS(SET_WINS)) u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .edge_mode_i (edge_mode),
      .hit_i       (hit),
      .ack_i       (ack_i),
      .clr_i       (clr_i),
      .flag_o      (flag)
   );

   always_comb begin
      case (sense_e'(sense_i))
         SENSE_LOW:  pending_o = ~pin_cur;
         SENSE_RSVD: pending_o = 1'b0;
         default:    pending_o = flag;
      endcase
   end

   assign req_o   = pending_o & src_en_i & gie_i;
   assign level_o = ~pin_cur;

   assert_low_nonlatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SENSE_LOW && pin_cur) |-> !req_o);

   assert_rsvd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SENSE_RSVD) |-> !req_o);

   assert_sync_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_prev && pin_cur && edge_mode && !flag) |=> !(flag && pin_prev));

endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b1;
   logic [1:0] sense = 2'b10;
   logic       src_en = 1'b0, gie = 1'b0, ack = 1'b0, clr = 1'b0;
   logic       pending, req, level;
   int         n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   ext_irq_sense uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense),
      .src_en_i(src_en), .gie_i(gie), .ack_i(ack), .clr_i(clr),
      .pending_o(pending), .req_o(req), .level_o(level)
   );

   // {sense[1:0], gie, src_en, pin_before, pin_after, exp_pending, exp_req, exp_level}
   localparam int NV = 12;
   localparam logic [8:0] VEC [0:NV-1] = '{
      9'b00_11_10_111,  // R2 low level asserts request
      9'b00_11_01_000,  // R2 level gone, no latch
      9'b00_01_10_101,  // R8 global enable off
      9'b01_11_10_001,  // R3 reserved ignores low
      9'b01_11_01_000,  // R3 reserved ignores rise
      9'b10_11_10_111,  // R4 falling edge
      9'b10_11_01_000,  // R4 rising edge ignored in fall mode
      9'b11_11_01_110,  // R5 rising edge
      9'b11_11_10_001,  // R5 falling edge ignored in rise mode
      9'b10_10_10_101,  // R8 source enable off
      9'b11_00_01_100,  // R8 both enables off
      9'b11_01_10_001   // R11 level independent of enables
   };

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic pulse_clr();
      clr = 1'b1; wait_neg(1); clr = 1'b0;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(5);
      check("R1 pending after reset", pending, 1'b0);
      check("R1 req after reset", req, 1'b0);
      check("R1 level after reset", level, 1'b0);

      for (int i = 0; i < NV; i++) begin
         sense  = VEC[i][8:7];
         gie    = VEC[i][6];
         src_en = VEC[i][5];
         pin    = VEC[i][4];
         wait_neg(5);
         pulse_clr();
         pin = VEC[i][3];
         wait_neg(3);
         check($sformatf("vec%0d pending", i), pending, VEC[i][2]);
         check($sformatf("vec%0d req", i), req, VEC[i][1]);
         check($sformatf("vec%0d level", i), level, VEC[i][0]);
      end

      // R6 latency, falling mode
      sense = 2'b10; gie = 1'b1; src_en = 1'b1; pin = 1'b1;
      wait_neg(5); pulse_clr();
      pin = 1'b0;
      wait_neg(1);
      check("R6 level after one edge", level, 1'b0);
      wait_neg(1);
      check("R6 level after two edges", level, 1'b1);
      check("R6 pending after two edges", pending, 1'b0);
      wait_neg(1);
      check("R6 pending after three edges", pending, 1'b1);

      // R9 ack clears
      ack = 1'b1; wait_neg(1); ack = 1'b0;
      check("R9 ack clears", pending, 1'b0);
      check("R9 req drops", req, 1'b0);

      // R7 two-cycle pulse in rise mode
      sense = 2'b11; pin = 1'b0; wait_neg(5); pulse_clr();
      pin = 1'b1; wait_neg(2); pin = 1'b0;
      wait_neg(4);
      check("R7 short pulse caught", pending, 1'b1);
      pulse_clr();
      check("R9 write-one clear", pending, 1'b0);

      // R9 set wins over simultaneous ack
      sense = 2'b10; pin = 1'b1; wait_neg(5); pulse_clr();
      pin = 1'b0;
      wait_neg(2);
      ack = 1'b1; wait_neg(1); ack = 1'b0;
      check("R9 set wins over ack", pending, 1'b1);

      // R10 leave edge mode clears sticky flag
      sense = 2'b01; wait_neg(1);
      sense = 2'b10; wait_neg(1);
      check("R10 flag cleared by mode change", pending, 1'b0);

      // R2 low mode follows pin back high
      sense = 2'b00; pin = 1'b0; wait_neg(4);
      check("R2 low active", req, 1'b1);
      pin = 1'b1; wait_neg(2);
      check("R2 low released", pending, 1'b0);

      // R1 reset release with pin high, falling mode
      sense = 2'b10; pin = 1'b1;
      rst_n = 1'b0; wait_neg(2); rst_n = 1'b1;
      wait_neg(5);
      check("R1 no false edge on release", pending, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule